// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers 96 level-sensitive interrupt sources into two processor request lines. One line is a normal request and the other a fast request. The sources are grouped into three banks of 32. Each bank has a mask register and a fast-route select register, and software reads and writes them over a plain 32-bit register bus. A source counts as active while its input is high and its mask bit is clear. Any active source raises the normal request. An active source whose select bit is set also raises the fast request.

A read-only vector register always holds the byte offset of the winning source. The winner is the lowest-numbered active source, so the handler can index a table of 4-byte entries with no search. The pending view that software reads is the live source level, and writes to it are dropped. A separate sticky fast-pending register records fast requests until software clears them by writing ones. The block also provides a word-aligned base-address register and two general storage registers.

Source n is bank n/32, bit n%32, and it arrives on `src_i[n]`.

Top module: `vectored_intc`

## Requirements
- R1: A read of an IRQ-pending word returns that bank's live source levels. The IRQ-pending words sit at group 1 (addr[7:4]=1), bank = addr[3:2]. A bit reads 1 while its input is high and 0 as soon as the input is low.
- R2: Writes to the IRQ-pending words have no effect. A later read still returns the source levels.
- R3: `irq_o` is high exactly when some source is high and its mask bit is clear. Mask words sit at group 4; a mask bit of 1 blocks its source.
- R4: `fiq_o` is high exactly when some source is high, unmasked, and has its select bit set. Select words sit at group 3 and read back what was written.
- R5: `vec_o` and the vector word (address 0x00) equal 4 × n for the lowest-numbered unmasked high source n. Bank 0 is searched first, and within a bank bit 0 first. The vector is 0 when no such source exists.
- R6: Writes to address 0x00 change nothing. The vector keeps following R5.
- R7: The fast-pending words sit at group 2. A bit becomes 1 on the clock after its source is high, unmasked and selected, and it then stays 1. A write to the word clears each bit where the write data is 1. If the bit's fast condition holds in the same cycle as the clearing write, the bit stays 1.
- R8: The base-address word (0x04) stores the written value with bits [1:0] forced to 0.
- R9: For the banked groups the bank index is addr[3:2]. Bank index 3 reads as 0 and ignores writes. Unassigned addresses read as 0.
- R10: Synchronous active-low reset sets all mask bits to 1 and clears select, fast-pending, base and the storage words. Right after reset both request lines are low, even with every source high.
- R11: Addresses 0x08 and 0x0C are plain 32-bit storage that reads back the last written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 96 | Source levels, bit n is source n |
| addr_i | input | 8 | Register byte address |
| wr_en_i | input | 1 | Write strobe for the current address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the current address, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| vec_o | output | 32 | Byte offset of the winning source |

## Verification
The assertions assume that the source levels, address and write strobe are stable across the sampling edge and hold no unknown values once reset is released. They also assume that the address upper bits encode one of the listed groups or an unused value that the block must read as zero. The bench changes every input only at the falling edge. It chooses addresses from the five groups and all four bank indices, including the unused index 3, so each input is settled and defined whenever the design samples it. Source 0 alone and no source at all both give vector 0. The bench tells these two cases apart through the request line and the pending word.

// File: rtl/vintc_pkg.sv
// Package: shared decode constants for the vectored interrupt controller.
// Assumes the register address splits into a group field in bits [7:4]
// and a word or bank field in bits [3:2].
package vintc_pkg;

    localparam int GRP_CTRL     = 0;
    localparam int GRP_IRQ_PEND = 1;
    localparam int GRP_FIQ_PEND = 2;
    localparam int GRP_FIQ_SEL  = 3;
    localparam int GRP_MASK     = 4;

    typedef enum logic [1:0] {
        CW_VECTOR  = 2'd0,
        CW_BASE    = 2'd1,
        CW_STORE_A = 2'd2,
        CW_STORE_B = 2'd3
    } ctrl_word_e;

endpackage

// File: rtl/vintc_decode.sv
// Module: address decode for the register bus.
// Produces one flag per register group, the bank index with its range check,
// and per-bank and per-control-word write strobes.
// Assumes NUM_BANKS <= 4 (bank index is two bits) and ADDR_W >= 5.
module vintc_decode
    import vintc_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 wr_en_i,
    output logic                 is_ctrl_o,
    output logic                 is_ipend_o,
    output logic                 is_fpend_o,
    output logic                 is_sel_o,
    output logic                 is_mask_o,
    output logic [1:0]           bank_o,
    output logic                 bank_ok_o,
    output ctrl_word_e           ctrl_word_o,
    output logic [NUM_BANKS-1:0] mask_we_o,
    output logic [NUM_BANKS-1:0] sel_we_o,
    output logic [NUM_BANKS-1:0] fclr_we_o,
    output logic                 base_we_o,
    output logic                 store_a_we_o,
    output logic                 store_b_we_o
);
    localparam int GRP_W = ADDR_W - 4;

    logic [GRP_W-1:0] grp_field;

    // Split the address into group and word fields.
    always_comb begin
        grp_field   = addr_i[ADDR_W-1:4];
        bank_o      = addr_i[3:2];
        ctrl_word_o = ctrl_word_e'(addr_i[3:2]);
        bank_ok_o   = ({30'd0, addr_i[3:2]} < 32'(NUM_BANKS));
    end

    // Group flags; at most one is set.
    always_comb begin
        is_ctrl_o  = (grp_field == GRP_W'(GRP_CTRL));
        is_ipend_o = (grp_field == GRP_W'(GRP_IRQ_PEND));
        is_fpend_o = (grp_field == GRP_W'(GRP_FIQ_PEND));
        is_sel_o   = (grp_field == GRP_W'(GRP_FIQ_SEL));
        is_mask_o  = (grp_field == GRP_W'(GRP_MASK));
    end

    // Control word write strobes; the vector word has none.
    always_comb begin
        base_we_o    = wr_en_i && is_ctrl_o && (ctrl_word_o == CW_BASE);
        store_a_we_o = wr_en_i && is_ctrl_o && (ctrl_word_o == CW_STORE_A);
        store_b_we_o = wr_en_i && is_ctrl_o && (ctrl_word_o == CW_STORE_B);
    end

    // Per-bank write strobes; IRQ-pending writes produce no strobe.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_we
        always_comb begin
            mask_we_o[b] = wr_en_i && is_mask_o  && (bank_o == 2'(b));
            sel_we_o[b]  = wr_en_i && is_sel_o   && (bank_o == 2'(b));
            fclr_we_o[b] = wr_en_i && is_fpend_o && (bank_o == 2'(b));
        end
    end

endmodule

// File: rtl/vintc_bank.sv
// Module: state for one bank of sources.
// Holds mask, fast-route select and sticky fast-pending bits.
// Reports the unmasked (active) and fast-active source vectors.
// Assumes the source levels are already synchronous to clk.
module vintc_bank #(
    parameter int BANK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] src_i,
    input  logic [BANK_W-1:0] wdata_i,
    input  logic              mask_we_i,
    input  logic              sel_we_i,
    input  logic              fclr_we_i,
    output logic [BANK_W-1:0] mask_o,
    output logic [BANK_W-1:0] sel_o,
    output logic [BANK_W-1:0] fpend_o,
    output logic [BANK_W-1:0] act_o,
    output logic [BANK_W-1:0] fact_o
);
    logic [BANK_W-1:0] fclr_bits;

    // Mask register: resets to all ones so that nothing is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_o <= '1;
        else if (mask_we_i) mask_o <= wdata_i;
    end

    // Fast-route select register.
    always_ff @(posedge clk) begin
        if (!rst_n)        sel_o <= '0;
        else if (sel_we_i) sel_o <= wdata_i;
    end

    // Active vectors seen by the request lines and the priority search.
    always_comb begin
        act_o     = src_i & ~mask_o;
        fact_o    = act_o & sel_o;
        fclr_bits = fclr_we_i ? wdata_i : '0;
    end

    // Sticky fast-pending: a new request wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) fpend_o <= '0;
        else        fpend_o <= (fpend_o & ~fclr_bits) | fact_o;
    end

endmodule

// File: rtl/vintc_prio.sv
// Module: lowest-index-first search over the active source vector.
// Reports whether any bit is set and the index of the lowest set bit.
// Purely combinational. Assumes NUM_SRC >= 2.
module vintc_prio #(
    parameter int NUM_SRC = 96,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] act_i,
    output logic               found_o,
    output logic [IDX_W-1:0]   idx_o
);
    // Scan from the top down so that the lowest set bit is written last.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (act_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/vectored_intc.sv
// Module: top of the vectored interrupt controller.
// Combines the banks, the priority search, the control words and the
// read-back mux. Read data is combinational on the address.
// Assumes BANK_W <= DATA_W and NUM_BANKS <= 4.
module vectored_intc
    import vintc_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_BANKS*BANK_W-1:0] src_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic                        wr_en_i,
    input  logic [DATA_W-1:0]           wdata_i,
    output logic [DATA_W-1:0]           rdata_o,
    output logic                        irq_o,
    output logic                        fiq_o,
    output logic [DATA_W-1:0]           vec_o
);
    localparam int NUM_SRC = NUM_BANKS * BANK_W;
    localparam int IDX_W   = $clog2(NUM_SRC);
    localparam int VPAD_W  = DATA_W - IDX_W - 2;

    logic                 is_ctrl, is_ipend, is_fpend, is_sel, is_mask;
    logic [1:0]           bank_idx;
    logic                 bank_ok;
    ctrl_word_e           ctrl_word;
    logic [NUM_BANKS-1:0] mask_we, sel_we, fclr_we;
    logic                 base_we, store_a_we, store_b_we;

    logic [BANK_W-1:0]    mask_q  [NUM_BANKS];
    logic [BANK_W-1:0]    sel_q   [NUM_BANKS];
    logic [BANK_W-1:0]    fpend_q [NUM_BANKS];
    logic [BANK_W-1:0]    src_b   [NUM_BANKS];
    logic [NUM_SRC-1:0]   act_flat, fact_flat;

    logic                 win_found;
    logic [IDX_W-1:0]     win_idx;

    logic [DATA_W-1:0]    base_q, store_a_q, store_b_q;

    vintc_decode #(
        .NUM_BANKS (NUM_BANKS),
        .ADDR_W    (ADDR_W)
    ) u_decode (
        .addr_i       (addr_i),
        .wr_en_i      (wr_en_i),
        .is_ctrl_o    (is_ctrl),
        .is_ipend_o   (is_ipend),
        .is_fpend_o   (is_fpend),
        .is_sel_o     (is_sel),
        .is_mask_o    (is_mask),
        .bank_o       (bank_idx),
        .bank_ok_o    (bank_ok),
        .ctrl_word_o  (ctrl_word),
        .mask_we_o    (mask_we),
        .sel_we_o     (sel_we),
        .fclr_we_o    (fclr_we),
        .base_we_o    (base_we),
        .store_a_we_o (store_a_we),
        .store_b_we_o (store_b_we)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign src_b[b] = src_i[b*BANK_W +: BANK_W];

        vintc_bank #(
            .BANK_W (BANK_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_i     (src_b[b]),
            .wdata_i   (wdata_i[BANK_W-1:0]),
            .mask_we_i (mask_we[b]),
            .sel_we_i  (sel_we[b]),
            .fclr_we_i (fclr_we[b]),
            .mask_o    (mask_q[b]),
            .sel_o     (sel_q[b]),
            .fpend_o   (fpend_q[b]),
            .act_o     (act_flat[b*BANK_W +: BANK_W]),
            .fact_o    (fact_flat[b*BANK_W +: BANK_W])
        );
    end

    vintc_prio #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_prio (
        .act_i   (act_flat),
        .found_o (win_found),
        .idx_o   (win_idx)
    );

    // Request lines and the vector as a byte offset.
    always_comb begin
        irq_o = |act_flat;
        fiq_o = |fact_flat;
        vec_o = win_found ? {{VPAD_W{1'b0}}, win_idx, 2'b00} : '0;
    end

    // Base-address word: stored word-aligned.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_we) base_q <= {wdata_i[DATA_W-1:2], 2'b00};
    end

    // General storage words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_a_q <= '0;
            store_b_q <= '0;
        end else begin
            if (store_a_we) store_a_q <= wdata_i;
            if (store_b_we) store_b_q <= wdata_i;
        end
    end

    // Read-back mux; unassigned addresses and bank index 3 read as zero.
    always_comb begin
        rdata_o = '0;
        if (is_ctrl) begin
            case (ctrl_word)
                CW_VECTOR:  rdata_o = vec_o;
                CW_BASE:    rdata_o = base_q;
                CW_STORE_A: rdata_o = store_a_q;
                CW_STORE_B: rdata_o = store_b_q;
                default:    rdata_o = '0;
            endcase
        end else if (bank_ok) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (bank_idx == 2'(b)) begin
                    if (is_ipend)      rdata_o = DATA_W'(src_b[b]);
                    else if (is_fpend) rdata_o = DATA_W'(fpend_q[b]);
                    else if (is_sel)   rdata_o = DATA_W'(sel_q[b]);
                    else if (is_mask)  rdata_o = DATA_W'(mask_q[b]);
                end
            end
        end
    end

endmodule

// File: rtl/vintc_checker.sv
// Module: temporal checks on the controller ports, bound into the top.
// Assumes inputs are settled and defined at each rising edge after reset.
module vintc_checker #(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_BANKS*BANK_W-1:0] src_i,
    input logic [ADDR_W-1:0]           addr_i,
    input logic [DATA_W-1:0]           rdata_o,
    input logic                        irq_o,
    input logic                        fiq_o,
    input logic [DATA_W-1:0]           vec_o
);
    localparam int NUM_SRC = NUM_BANKS * BANK_W;
    localparam int IDX_W   = $clog2(NUM_SRC);

    logic                 rd_ipend, rd_base;
    logic [BANK_W-1:0]    src_slice;
    logic [IDX_W-1:0]     vec_idx;

    // Decode the read address and pick the matching source slice.
    always_comb begin
        rd_ipend  = (addr_i[ADDR_W-1:4] == (ADDR_W-4)'(1))
                    && ({30'd0, addr_i[3:2]} < 32'(NUM_BANKS));
        rd_base   = (addr_i == ADDR_W'(4));
        src_slice = '0;
        for (int b = 0; b < NUM_BANKS; b++)
            if (addr_i[3:2] == 2'(b)) src_slice = src_i[b*BANK_W +: BANK_W];
        vec_idx   = vec_o[IDX_W+1:2];
    end

    p_pending_mirror_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ipend |-> rdata_o[BANK_W-1:0] == src_slice);

    p_fiq_needs_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> irq_o);

    p_vec_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> vec_o == '0);

    p_vec_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_o[1:0] == 2'b00);

    p_vec_source_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> src_i[vec_idx]);

    p_base_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_base |-> rdata_o[1:0] == 2'b00);

    p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!irq_o && !fiq_o));

endmodule

bind vectored_intc vintc_checker #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W)
) u_vintc_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_i   (src_i),
    .addr_i  (addr_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o),
    .fiq_o   (fiq_o),
    .vec_o   (vec_o)
);

// File: tb/vectored_intc_test.sv
// Bench: behavioural reference model compared against the design every clock.
module vectored_intc_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 96;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src = '0;
    logic [7:0]    addr = '0;
    logic          we = 1'b0;
    logic [31:0]   wd = '0;
    logic [31:0]   rdata, vec;
    logic          irq, fiq;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // Reference state
    logic [31:0] m_mask [3];
    logic [31:0] m_sel  [3];
    logic [31:0] m_fp   [3];
    logic [31:0] m_base, m_sa, m_sb;

    always #(CLK_PERIOD/2) clk = ~clk;

    vectored_intc uut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr),
        .wr_en_i(we), .wdata_i(wd), .rdata_o(rdata),
        .irq_o(irq), .fiq_o(fiq), .vec_o(vec)
    );

    function automatic bit src_on(int n);
        return src[n] && !m_mask[n/32][n%32];
    endfunction

    function automatic logic exp_irq();
        for (int n = 0; n < NS; n++) if (src_on(n)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic exp_fiq();
        for (int n = 0; n < NS; n++) if (src_on(n) && m_sel[n/32][n%32]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [31:0] exp_vec();
        for (int n = 0; n < NS; n++) if (src_on(n)) return 32'(n * 4);
        return 32'd0;
    endfunction

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        int g = a[7:4];
        int b = a[3:2];
        if (g == 0) begin
            case (b)
                0: return exp_vec();
                1: return m_base;
                2: return m_sa;
                default: return m_sb;
            endcase
        end
        if (b == 3) return 32'd0;
        case (g)
            1: return src[b*32 +: 32];
            2: return m_fp[b];
            3: return m_sel[b];
            4: return m_mask[b];
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rd_tag(logic [7:0] a);
        if (a[7:4] > 4) return "R9";
        if (a[7:4] != 0 && a[3:2] == 3) return "R9";
        case (a[7:4])
            0: case (a[3:2]) 0: return "R6"; 1: return "R8"; default: return "R11"; endcase
            1: return "R1";
            2: return "R7";
            3: return "R4";
            default: return "R3";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < 3; b++) begin
            m_mask[b] = '1; m_sel[b] = '0; m_fp[b] = '0;
        end
        m_base = '0; m_sa = '0; m_sb = '0;
    endtask

    // Apply one cycle's writes and sticky updates to the model.
    task automatic model_step();
        logic [31:0] fnew [3];
        for (int b = 0; b < 3; b++) begin
            fnew[b] = m_fp[b];
            if (we && addr == 8'(8'h20 + 4*b)) fnew[b] = fnew[b] & ~wd;
            fnew[b] = fnew[b] | (src[b*32 +: 32] & ~m_mask[b] & m_sel[b]);
        end
        for (int b = 0; b < 3; b++) m_fp[b] = fnew[b];
        if (we) begin
            for (int b = 0; b < 3; b++) begin
                if (addr == 8'(8'h30 + 4*b)) m_sel[b] = wd;
                if (addr == 8'(8'h40 + 4*b)) m_mask[b] = wd;
            end
            if (addr == 8'h04) m_base = wd & 32'hFFFF_FFFC;
            if (addr == 8'h08) m_sa = wd;
            if (addr == 8'h0C) m_sb = wd;
        end
    endtask

    // One clock: drive at negedge, compare settled outputs, then step model.
    task automatic cyc(logic [NS-1:0] s, logic [7:0] a, logic w, logic [31:0] d);
        @(negedge clk);
        src = s; addr = a; we = w; wd = d;
        #1;
        check("R3 irq", 32'(irq), 32'(exp_irq()));
        check("R4 fiq", 32'(fiq), 32'(exp_fiq()));
        check("R5 vec", vec, exp_vec());
        check(rd_tag(a), rdata, exp_rd(a));
        @(posedge clk);
        model_step();
    endtask

    function automatic logic [NS-1:0] bit_of(int n);
        logic [NS-1:0] v = '0;
        v[n] = 1'b1;
        return v;
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : main
        logic [NS-1:0] all1;
        all1 = '1;
        model_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10: reset values and quiet lines with every source high
        for (int g = 0; g < 5; g++)
            for (int b = 0; b < 4; b++) cyc(all1, 8'((g << 4) | (b << 2)), 1'b0, '0);
        @(negedge clk); #1;
        check("R10 irq after reset", 32'(irq), 32'd0);
        check("R10 fiq after reset", 32'(fiq), 32'd0);
        // R3/R5: unmask bank 0
        cyc('0, 8'h40, 1'b1, 32'h0);
        cyc(bit_of(5), 8'h00, 1'b0, '0);
        cyc(bit_of(5) | bit_of(9), 8'h10, 1'b0, '0);
        // R5: source 0 versus nothing pending
        cyc(bit_of(0), 8'h10, 1'b0, '0);
        @(negedge clk); #1;
        check("R5 src0 irq", 32'(irq), 32'd1);
        check("R5 src0 vec", vec, 32'd0);
        cyc('0, 8'h10, 1'b0, '0);
        @(negedge clk); #1;
        check("R5 idle irq", 32'(irq), 32'd0);
        // unmask banks 1 and 2; bank-crossing priority
        cyc('0, 8'h44, 1'b1, 32'h0);
        cyc('0, 8'h48, 1'b1, 32'h0);
        cyc(bit_of(40) | bit_of(70), 8'h00, 1'b0, '0);
        @(negedge clk); #1;
        check("R5 vec 40", vec, 32'd160);
        cyc(bit_of(40) | bit_of(70), 8'h44, 1'b1, 32'h0000_0100);
        @(negedge clk); #1;
        check("R3 vec after mask", vec, 32'd280);
        // R4/R7: route source 70 (bank2 bit6) to the fast line
        cyc(bit_of(70), 8'h38, 1'b1, 32'h40);
        cyc(bit_of(70), 8'h28, 1'b0, '0);
        cyc('0, 8'h28, 1'b0, '0);
        cyc('0, 8'h28, 1'b1, 32'h1);
        cyc('0, 8'h28, 1'b0, '0);
        @(negedge clk); #1;
        check("R7 sticky kept", rdata, 32'h40);
        cyc(bit_of(70), 8'h28, 1'b1, 32'h40);
        cyc('0, 8'h28, 1'b0, '0);
        @(negedge clk); #1;
        check("R7 set wins clear", rdata, 32'h40);
        cyc('0, 8'h28, 1'b1, 32'h40);
        cyc('0, 8'h28, 1'b0, '0);
        @(negedge clk); #1;
        check("R7 cleared", rdata, 32'h0);
        // R2/R6: ignored writes
        cyc(bit_of(33), 8'h14, 1'b1, 32'h0);
        cyc(bit_of(33), 8'h14, 1'b0, '0);
        cyc(bit_of(33), 8'h00, 1'b1, 32'hFFFF_FFFF);
        cyc(bit_of(33), 8'h00, 1'b0, '0);
        @(negedge clk); #1;
        check("R6 vector unchanged", rdata, 32'd132);
        check("R2 pending still live", 32'(src[33]), 32'd1);
        // R8/R11
        cyc('0, 8'h04, 1'b1, 32'hFFFF_FFFF);
        cyc('0, 8'h04, 1'b0, '0);
        cyc('0, 8'h08, 1'b1, 32'hA5A5_0003);
        cyc('0, 8'h0C, 1'b1, 32'h1234_5678);
        cyc('0, 8'h08, 1'b0, '0);
        cyc('0, 8'h0C, 1'b0, '0);
        // R9: bank 3 and unused groups
        cyc('0, 8'h4C, 1'b1, 32'h0);
        cyc('0, 8'h4C, 1'b0, '0);
        cyc('0, 8'h50, 1'b1, 32'hFFFF_FFFF);
        cyc('0, 8'h50, 1'b0, '0);
        // mixed traffic
        for (int k = 0; k < 400; k++) begin
            logic [NS-1:0] s;
            logic [7:0]    a;
            s = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
            a = 8'(($urandom_range(0, 5) << 4) | ($urandom_range(0, 3) << 2));
            cyc(s, a, 1'($urandom_range(0, 3) == 0), $urandom);
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule